// File: doc/BRIEF.md
# Address-window access filter

This block sits between requesters on an on-chip interconnect and a single-cycle on-chip memory. Each request carries an address, a direction (read or write) and a flag that says whether the requester is trusted. The filter checks the address against a small set of address windows. Each window holds its own read permission bit and its own write permission bit for untrusted requesters. Because the two bits are separate, a window can be readable by untrusted software without being writable by it.

Trusted requests always pass. An untrusted request passes only when the first window that contains its address grants the requested direction. An untrusted request whose address is in no window is refused. A request that passes is presented to the memory in the same cycle. A refused request never reaches the memory. Every request, whether it passed or was refused, gets exactly one response one cycle later. That response carries an error flag and read data. The read data is zero for writes and for refused requests.

The window bounds and permissions sit in registers that are loaded at reset. Window 0 spans 0xA0000000 to 0xA000FFFF and allows both directions. Window 1 spans 0xA0010000 to 0xA001FFFF and allows reads only.

Top module: `awin_access_filter`

## Requirements
- R1: While reset is high and in the first cycle after it, `rsp_valid` is 0 and `mem_en` is 0 when no request is presented.
- R2: A request with `req_trusted`=1 is forwarded (`mem_en`=1 in the same cycle) at any address, in either direction.
- R3: An untrusted read or write to an address in 0xA0000000..0xA000FFFF is forwarded.
- R4: An untrusted read to an address in 0xA0010000..0xA001FFFF is forwarded. An untrusted write to that range is blocked (`mem_en`=0) and gets an error response. Read and write permission come from separate bits.
- R5: An untrusted request, read or write, to an address outside every window is blocked and gets an error response.
- R6: Window bounds are inclusive on full 32-bit addresses. 0xA0000000, 0xA000FFFF, 0xA0010000 and 0xA001FFFF hit their windows. 0x9FFFFFFF and 0xA0020000 miss every window.
- R7: Every cycle with `req_valid`=1 gives exactly one cycle with `rsp_valid`=1, one cycle later, and no response appears without a request. `rsp_err`=1 for a blocked request, with `rsp_rdata`=0. A forwarded read returns the word the memory held at that address, with `rsp_err`=0. A forwarded write returns `rsp_err`=0 and `rsp_rdata`=0.
- R8: `mem_en` is 0 whenever `req_valid` is 0. When `mem_en`=1, `mem_addr` equals `req_addr` and `mem_we` equals `req_write`. A forwarded write presents `req_wdata` on `mem_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; loads the window registers |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_trusted | input | 1 | 1 = trusted requester |
| req_addr | input | ADDR_W | Request byte address |
| req_wdata | input | DATA_W | Write data |
| mem_en | output | 1 | Request forwarded to the memory this cycle |
| mem_we | output | 1 | Forwarded request is a write |
| mem_addr | output | ADDR_W | Forwarded address |
| mem_wdata | output | DATA_W | Forwarded write data (zero unless a write is forwarded) |
| mem_rdata | input | DATA_W | Memory read data, valid one cycle after `mem_en` |
| rsp_valid | output | 1 | Response to the request of the previous cycle |
| rsp_err | output | 1 | Request was refused |
| rsp_rdata | output | DATA_W | Read data (zero for writes and refusals) |

## Verification
The forward signals (`mem_en`, `mem_we`, `mem_addr`, `mem_wdata`) are due in the same cycle as the request. The bench samples them 1 ns after it drives the inputs at the falling edge. The response (`rsp_valid`, `rsp_err`, `rsp_rdata`) is due one rising edge later. The bench keeps the expected response of each request pending and compares it at the next falling edge, before it drives the next request, so back-to-back traffic is checked in order. Expected read data comes from a shadow copy of the bench memory that is updated only by writes the bench expects to be forwarded. A wrongly admitted write therefore also shows up as wrong data on a later read.

// File: rtl/awin_pkg.sv
package awin_pkg;

  // Reset contents of the two default windows
  localparam logic [31:0] RW_WIN_BASE  = 32'hA000_0000;
  localparam logic [31:0] RW_WIN_LIMIT = 32'hA000_FFFF;
  localparam logic [31:0] RO_WIN_BASE  = 32'hA001_0000;
  localparam logic [31:0] RO_WIN_LIMIT = 32'hA001_FFFF;

  // Untrusted-requester permission of one window
  typedef struct packed {
    logic rd;
    logic wr;
  } perm_t;

endpackage

// File: rtl/awin_win_regs.sv
module awin_win_regs #(
  parameter int ADDR_W  = 32,
  parameter int NUM_WIN = 2,
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] RST_BASE  = '0,
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] RST_LIMIT = '0,
  parameter logic [NUM_WIN-1:0]             RST_RD    = '0,
  parameter logic [NUM_WIN-1:0]             RST_WR    = '0
) (
  input  logic                              clk,
  input  logic                              rst,
  output logic [NUM_WIN-1:0][ADDR_W-1:0]    base_q,
  output logic [NUM_WIN-1:0][ADDR_W-1:0]    limit_q,
  output awin_pkg::perm_t [NUM_WIN-1:0]     perm_q
);

  // One register set per window, loaded at reset and held afterwards
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    always_ff @(posedge clk) begin
      if (rst) begin
        base_q[w]     <= RST_BASE[w];
        limit_q[w]    <= RST_LIMIT[w];
        perm_q[w].rd  <= RST_RD[w];
        perm_q[w].wr  <= RST_WR[w];
      end
    end
  end

endmodule

// File: rtl/awin_win_match.sv
module awin_win_match #(
  parameter int ADDR_W  = 32,
  parameter int NUM_WIN = 2
) (
  input  logic [ADDR_W-1:0]              addr,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0] base,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0] limit,
  output logic [NUM_WIN-1:0]             hit
);

  // Inclusive full-width bounds compare for each window
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
    logic above_base;
    logic below_limit;
    assign above_base  = (addr >= base[w]);
    assign below_limit = (addr <= limit[w]);
    assign hit[w]      = above_base & below_limit;
  end

endmodule

// File: rtl/awin_perm_resolve.sv
module awin_perm_resolve #(
  parameter int NUM_WIN = 2
) (
  input  logic                          valid,
  input  logic                          write,
  input  logic                          trusted,
  input  logic [NUM_WIN-1:0]            hit,
  input  awin_pkg::perm_t [NUM_WIN-1:0] perm,
  output logic                          allow
);

  logic found;
  logic grant;

  // Lowest-index hit decides; direction picks the read or write bit
  always_comb begin
    found = 1'b0;
    grant = 1'b0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (hit[w] && !found) begin
        found = 1'b1;
        grant = write ? perm[w].wr : perm[w].rd;
      end
    end
  end

  assign allow = valid & (trusted | grant);

endmodule

// File: rtl/awin_resp_stage.sv
module awin_resp_stage #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic              allow,
  input  logic              write,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata
);

  logic vld_q;
  logic err_q;
  logic rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      err_q <= 1'b0;
      rd_q  <= 1'b0;
    end else begin
      vld_q <= valid;
      err_q <= valid & ~allow;
      rd_q  <= valid & allow & ~write;
    end
  end

  assign rsp_valid = vld_q;
  assign rsp_err   = err_q;
  assign rsp_rdata = rd_q ? mem_rdata : '0;

endmodule

// File: rtl/awin_access_filter.sv
module awin_access_filter #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int NUM_WIN = 2,
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] WIN_BASE  =
    {awin_pkg::RO_WIN_BASE,  awin_pkg::RW_WIN_BASE},
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] WIN_LIMIT =
    {awin_pkg::RO_WIN_LIMIT, awin_pkg::RW_WIN_LIMIT},
  parameter logic [NUM_WIN-1:0] WIN_RD = 2'b11,
  parameter logic [NUM_WIN-1:0] WIN_WR = 2'b01
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_trusted,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata
);

  logic [NUM_WIN-1:0][ADDR_W-1:0] base_q;
  logic [NUM_WIN-1:0][ADDR_W-1:0] limit_q;
  awin_pkg::perm_t [NUM_WIN-1:0]  perm_q;
  logic [NUM_WIN-1:0]             hit;
  logic                           allow;

  awin_win_regs #(
    .ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN),
    .RST_BASE(WIN_BASE), .RST_LIMIT(WIN_LIMIT),
    .RST_RD(WIN_RD), .RST_WR(WIN_WR)
  ) u_regs (
    .clk(clk), .rst(rst),
    .base_q(base_q), .limit_q(limit_q), .perm_q(perm_q)
  );

  awin_win_match #(.ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN)) u_match (
    .addr(req_addr), .base(base_q), .limit(limit_q), .hit(hit)
  );

  awin_perm_resolve #(.NUM_WIN(NUM_WIN)) u_resolve (
    .valid(req_valid), .write(req_write), .trusted(req_trusted),
    .hit(hit), .perm(perm_q), .allow(allow)
  );

  awin_resp_stage #(.DATA_W(DATA_W)) u_resp (
    .clk(clk), .rst(rst),
    .valid(req_valid), .allow(allow), .write(req_write),
    .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
  );

  // Forward path: a refused request never reaches the memory
  assign mem_en    = allow;
  assign mem_we    = allow & req_write;
  assign mem_addr  = req_addr;
  assign mem_wdata = (allow & req_write) ? req_wdata : '0;

endmodule

// File: rtl/awin_access_filter_chk.sv
module awin_access_filter_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic              req_trusted,
  input logic [ADDR_W-1:0] req_addr,
  input logic              mem_en,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [DATA_W-1:0] rsp_rdata
);

  logic in_ro;
  logic outside;
  assign in_ro   = (req_addr >= awin_pkg::RO_WIN_BASE) && (req_addr <= awin_pkg::RO_WIN_LIMIT);
  assign outside = (req_addr < awin_pkg::RW_WIN_BASE) || (req_addr > awin_pkg::RO_WIN_LIMIT);

  // R8
  idle_no_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |-> !mem_en);

  // R8
  fwd_fields_chk: assert property (@(posedge clk) disable iff (rst)
    mem_en |-> (mem_addr == req_addr) && (mem_we == req_write));

  // R2
  trusted_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_trusted) |-> mem_en);

  // R4
  ro_write_block_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_trusted && req_write && in_ro) |-> !mem_en);

  // R5
  outside_block_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_trusted && outside) |-> !mem_en);

  // R7
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  // R7
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  // R7
  deny_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !mem_en) |=> (rsp_err && rsp_rdata == '0));

  // R7
  allow_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    mem_en |=> !rsp_err);

endmodule

bind awin_access_filter awin_access_filter_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst),
  .req_valid(req_valid), .req_write(req_write), .req_trusted(req_trusted),
  .req_addr(req_addr),
  .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
);

// File: tb/awin_access_filter_tb.sv
`timescale 1ns/1ps
module awin_access_filter_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_trusted = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        mem_en, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  awin_access_filter u_dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .req_trusted(req_trusted),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
  );

  // Small single-cycle memory model, word index addr[5:2]
  logic [31:0] mem [16];
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 16; i++) mem[i] <= 32'h5A00_0000 + i;
      mem_rdata <= '0;
    end else if (mem_en) begin
      if (mem_we) mem[mem_addr[5:2]] <= mem_wdata;
      mem_rdata <= mem[mem_addr[5:2]];
    end
  end

  logic [31:0] shadow [16];
  bit          pend_v = 1'b0, pend_err = 1'b0;
  logic [31:0] pend_rd = '0;
  string       pend_tag = "R7";

  function automatic bit exp_allow(logic [31:0] a, bit w, bit t);
    if (t) return 1'b1;
    if (a >= 32'hA000_0000 && a <= 32'hA000_FFFF) return 1'b1;
    if (a >= 32'hA001_0000 && a <= 32'hA001_FFFF) return !w;
    return 1'b0;
  endfunction

  function automatic string region_tag(logic [31:0] a, bit t);
    if (t) return "R2";
    if (a >= 32'hA000_0000 && a <= 32'hA000_FFFF) return "R3";
    if (a >= 32'hA001_0000 && a <= 32'hA001_FFFF) return "R4";
    return "R5";
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Runs at a falling edge: check the pending response, drive, check forward
  task automatic step(bit v, bit w, bit t, logic [31:0] a, logic [31:0] d, string tag);
    bit al;
    if (pend_v) begin
      check(pend_tag, "rsp_valid", {31'b0, rsp_valid}, 32'd1);
      check(pend_tag, "rsp_err",   {31'b0, rsp_err},   {31'b0, pend_err});
      check(pend_tag, "rsp_rdata", rsp_rdata, pend_rd);
    end else begin
      check("R7", "rsp_valid idle", {31'b0, rsp_valid}, 32'd0);
    end
    req_valid = v; req_write = w; req_trusted = t; req_addr = a; req_wdata = d;
    #1;
    al = v && exp_allow(a, w, t);
    check(v ? tag : "R8", "mem_en", {31'b0, mem_en}, {31'b0, al});
    if (al) begin
      check("R8", "mem_addr", mem_addr, a);
      check("R8", "mem_we", {31'b0, mem_we}, {31'b0, w});
      if (w) check("R8", "mem_wdata", mem_wdata, d);
    end
    pend_v   = v;
    pend_err = v && !al;
    pend_tag = (tag == "R6") ? "R6" : "R7";
    pend_rd  = (al && !w) ? shadow[a[5:2]] : 32'd0;
    if (al && w) shadow[a[5:2]] = d;
    @(negedge clk);
  endtask

  task automatic req(bit w, bit t, logic [31:0] a, logic [31:0] d, string tag);
    step(1'b1, w, t, a, d, tag);
  endtask

  initial begin
    logic [31:0] a;
    int unsigned sel;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) shadow[i] = 32'h5A00_0000 + i;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1", "rsp_valid in reset", {31'b0, rsp_valid}, 32'd0);
    check("R1", "mem_en in reset",    {31'b0, mem_en},    32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "rsp_valid after reset", {31'b0, rsp_valid}, 32'd0);
    step(1'b0, 1'b0, 1'b0, 32'h0, 32'h0, "R1");

    // Directed: read/write window, read-only window, outside, trusted
    req(1'b1, 1'b0, 32'hA000_0010, 32'h1111_0001, "R3");
    req(1'b0, 1'b0, 32'hA000_0010, 32'h0,         "R3");
    req(1'b0, 1'b0, 32'hA001_0020, 32'h0,         "R4");
    req(1'b1, 1'b0, 32'hA001_0020, 32'hDEAD_BEEF, "R4");
    req(1'b0, 1'b0, 32'hA001_0020, 32'h0,         "R4");
    req(1'b0, 1'b0, 32'h4000_0000, 32'h0,         "R5");
    req(1'b1, 1'b0, 32'hFFFF_FFFC, 32'h0BAD_0BAD, "R5");
    req(1'b1, 1'b1, 32'hA001_0024, 32'h2222_0002, "R2");
    req(1'b0, 1'b1, 32'h0000_0028, 32'h0,         "R2");
    req(1'b0, 1'b0, 32'hA000_0024, 32'h0,         "R2");
    // Directed: inclusive boundaries
    req(1'b0, 1'b0, 32'h9FFF_FFFF, 32'h0,         "R6");
    req(1'b1, 1'b0, 32'hA000_0000, 32'h3333_0003, "R6");
    req(1'b1, 1'b0, 32'hA000_FFFF, 32'h4444_0004, "R6");
    req(1'b1, 1'b0, 32'hA001_0000, 32'h5555_0005, "R6");
    req(1'b0, 1'b0, 32'hA001_0000, 32'h0,         "R6");
    req(1'b0, 1'b0, 32'hA001_FFFF, 32'h0,         "R6");
    req(1'b0, 1'b0, 32'hA002_0000, 32'h0,         "R6");
    step(1'b0, 1'b0, 1'b0, 32'h0, 32'h0, "R8");

    // Random traffic around the windows, with idle gaps
    for (int n = 0; n < 3000; n++) begin
      sel = $urandom % 6;
      case (sel)
        0: a = 32'hA000_0000 + ($urandom & 32'h0000_FFFF);
        1: a = 32'hA001_0000 + ($urandom & 32'h0000_FFFF);
        2: a = 32'h9FFF_FFF0 + ($urandom & 32'h1F);
        3: a = 32'hA001_FFF0 + ($urandom & 32'h1F);
        4: a = 32'hA000_FFF0 + ($urandom & 32'h1F);
        default: a = $urandom;
      endcase
      if (($urandom % 8) == 0)
        step(1'b0, 1'b0, 1'b0, a, 32'h0, "R8");
      else begin
        bit t;
        t = (($urandom % 5) == 0);
        req(bit'($urandom & 1), t, a, $urandom, region_tag(a, t));
      end
    end
    step(1'b0, 1'b0, 1'b0, 32'h0, 32'h0, "R7");
    step(1'b0, 1'b0, 1'b0, 32'h0, 32'h0, "R7");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule